// File: doc/BRIEF.md
# Dual-Packet Endpoint Transmit FIFO

This block buffers outgoing data for a single IN endpoint. A local processor pushes payload bytes into a circular store. It then writes a 16-bit byte count as two bytes, low first and high second. Writing the high byte turns the bytes written so far into a queued data set. At most two data sets can wait at once, and each keeps its own length.

On the other side, a serial engine sees the length of the oldest data set and drains its bytes one per read strobe. At the end of the IN transaction it reports either success or failure. Success frees the data set's bytes. Failure rewinds the read position to the first byte of the same data set, so the host can retry it.

A status byte shows four things: how many data sets are queued, whether the store is empty, whether it is full, and a sticky overrun flag. A clear strobe returns the whole buffer to its empty state.

Top module: `txf_dual_pkt`

## Requirements
- R1: After reset, `flags` reads 8'h08, `eng_avail` is low and `eng_count` is 0.
- R2: The serial engine receives the bytes of a data set in the order they were written, including when the read and write positions wrap past the end of the array.
- R3: A high-byte count write (`cnt_hi_we`) commits a data set. Its length is {high byte, last low byte}, clamped to DEPTH when larger. The queued-set count goes up by one, and `eng_count` always shows the length of the oldest queued set.
- R4: A commit is ignored while two data sets are queued. The queued-set count and `eng_count` stay the same.
- R5: `eng_done_ok` with a set queued releases the oldest set. Its bytes become free space, the queued-set count drops by one, and `eng_count` moves to the next set's length.
- R6: `eng_done_fail` with a set queued (and `eng_done_ok` low) rewinds the read position to that set's first byte. The queued-set count and `eng_count` are unchanged.
- R7: The full flag is set when the bytes not yet released, including bytes already read but not released, fill all DEPTH entries.
- R8: A processor byte write while the store is full sets the overrun flag, and the byte is discarded.
- R9: The overrun flag stays set until `ovf_clr` or `clr` is pulsed. If an overrun happens in the same cycle as `ovf_clr`, the flag stays set.
- R10: `clr` empties the store, resets all positions, drops every queued set and clears the overrun flag, so `flags` reads 8'h08.
- R11: `flags` layout: bits 7:6 hold the queued-set count in binary (0, 1 or 2), bit 3 is empty, bit 2 is full, bit 0 is overrun, and bits 5, 4 and 1 read 0.
- R12: `eng_rd_en` has no effect while no set is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Empty the buffer and drop all sets |
| cpu_wr_en | input | 1 | Processor payload byte write strobe |
| cpu_wr_data | input | 8 | Processor payload byte |
| cnt_lo_we | input | 1 | Store low byte of the pending byte count |
| cnt_hi_we | input | 1 | Supply high byte of the count and commit the set |
| cnt_data | input | 8 | Byte-count byte |
| ovf_clr | input | 1 | Clear the overrun flag |
| eng_rd_en | input | 1 | Serial engine consumes the current byte |
| eng_done_ok | input | 1 | IN transaction succeeded |
| eng_done_fail | input | 1 | IN transaction failed |
| eng_rd_data | output | 8 | Byte at the engine read position |
| eng_avail | output | 1 | At least one set queued |
| eng_count | output | AW+1 | Length of the oldest queued set |
| flags | output | 8 | Status byte (R11 layout) |

## Verification
The assertions assume a well-behaved serial engine. It reads no more bytes than `eng_count` before it reports an outcome, and it reports outcomes only while `eng_avail` is high. They also assume the processor commits only lengths it has actually written. The bench keeps to these rules. It computes every read from a known per-set byte pattern and sweeps both set lengths from 1 to 4 on an 8-entry store, so the positions wrap many times. The only deliberate breaks are the ignored cases. These are idle engine reads, a third commit, and writes beyond full. Each is checked at the ports through the bytes and flags that follow.

// File: rtl/txf_pkg.sv
package txf_pkg;
  // Status byte bit positions
  localparam int FLG_IDX_HI = 7;
  localparam int FLG_IDX_LO = 6;
  localparam int FLG_EMPTY  = 3;
  localparam int FLG_FULL   = 2;
  localparam int FLG_OVF    = 0;

  typedef logic [7:0] flag_byte_t;

  function automatic flag_byte_t pack_flags(input logic [1:0] sets, input logic empty,
                                            input logic full, input logic ovf);
    flag_byte_t f;
    f = '0;
    f[FLG_IDX_HI:FLG_IDX_LO] = sets;
    f[FLG_EMPTY] = empty;
    f[FLG_FULL]  = full;
    f[FLG_OVF]   = ovf;
    return f;
  endfunction
endpackage

// File: rtl/txf_store.sv
module txf_store #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/txf_ptrs.sv
module txf_ptrs #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          rd_step,
  input  logic          release_set,
  input  logic          rewind,
  input  logic [PW-1:0] head_cnt,
  output logic [PW-1:0] wr_p,
  output logic [PW-1:0] base_p,
  output logic [PW-1:0] rd_p,
  output logic          full,
  output logic          empty
);
  // Ring arithmetic: one extra bit tells full from empty
  function automatic logic [PW-1:0] ring_add(input logic [PW-1:0] p, input logic [PW-1:0] n);
    return p + n;
  endfunction

  function automatic logic [PW-1:0] ring_dist(input logic [PW-1:0] ahead, input logic [PW-1:0] behind);
    return ahead - behind;
  endfunction

  logic [PW-1:0] fill;
  logic [PW-1:0] next_base;

  assign fill      = ring_dist(wr_p, base_p);
  assign full      = (fill == PW'(DEPTH));
  assign empty     = (fill == '0);
  assign next_base = ring_add(base_p, head_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_p   <= '0;
      base_p <= '0;
      rd_p   <= '0;
    end else begin
      if (push) wr_p <= ring_add(wr_p, PW'(1));
      if (release_set) begin
        base_p <= next_base;
        rd_p   <= next_base;
      end else if (rewind) begin
        rd_p <= base_p;
      end else if (rd_step) begin
        rd_p <= ring_add(rd_p, PW'(1));
      end
    end
  end
endmodule

// File: rtl/txf_sets.sv
module txf_sets #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          commit_req,
  input  logic [CW-1:0] commit_cnt,
  input  logic          pop,
  output logic [1:0]    nsets,
  output logic [CW-1:0] head_cnt
);
  logic [CW-1:0] cnt_q [2];
  logic          take;

  assign take     = commit_req && (nsets != 2'd2);
  assign head_cnt = cnt_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      nsets    <= 2'd0;
      cnt_q[0] <= '0;
      cnt_q[1] <= '0;
    end else begin
      case ({pop, take})
        2'b11: begin
          if (nsets == 2'd1) cnt_q[0] <= commit_cnt;
        end
        2'b10: begin
          cnt_q[0] <= cnt_q[1];
          nsets    <= nsets - 2'd1;
        end
        2'b01: begin
          if (nsets == 2'd0) cnt_q[0] <= commit_cnt;
          else               cnt_q[1] <= commit_cnt;
          nsets <= nsets + 2'd1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/txf_dual_pkt.sv
module txf_dual_pkt #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cpu_wr_en,
  input  logic [7:0]    cpu_wr_data,
  input  logic          cnt_lo_we,
  input  logic          cnt_hi_we,
  input  logic [7:0]    cnt_data,
  input  logic          ovf_clr,
  input  logic          eng_rd_en,
  input  logic          eng_done_ok,
  input  logic          eng_done_fail,
  output logic [7:0]    eng_rd_data,
  output logic          eng_avail,
  output logic [CW-1:0] eng_count,
  output logic [7:0]    flags
);
  import txf_pkg::*;

  localparam int PW = CW;

  function automatic logic [CW-1:0] clamp_count(input logic [15:0] raw);
    return (raw > 16'(DEPTH)) ? CW'(DEPTH) : raw[CW-1:0];
  endfunction

  // Named event wires
  logic          full, empty, have_set;
  logic          wr_accept, wr_overrun, rd_step, release_set, rewind, commit_req;
  logic [1:0]    nsets;
  logic [CW-1:0] head_cnt, commit_cnt;
  logic [PW-1:0] wr_ptr, base_ptr, rd_ptr;
  logic [7:0]    cnt_lo_q;
  logic          ovf_q;

  assign have_set    = (nsets != 2'd0);
  assign wr_accept   = cpu_wr_en && !full && !clr;
  assign wr_overrun  = cpu_wr_en && full && !clr;
  assign release_set = eng_done_ok && have_set && !clr;
  assign rewind      = eng_done_fail && !eng_done_ok && have_set && !clr;
  assign rd_step     = eng_rd_en && have_set && !eng_done_ok && !eng_done_fail && !clr;
  assign commit_req  = cnt_hi_we && !clr;
  assign commit_cnt  = clamp_count({cnt_data, cnt_lo_q});

  always_ff @(posedge clk) begin
    if (!rst_n || clr)  cnt_lo_q <= '0;
    else if (cnt_lo_we) cnt_lo_q <= cnt_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr)    ovf_q <= 1'b0;
    else if (wr_overrun)  ovf_q <= 1'b1;
    else if (ovf_clr)     ovf_q <= 1'b0;
  end

  txf_store #(.DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (wr_accept),
    .waddr (wr_ptr[AW-1:0]),
    .wdata (cpu_wr_data),
    .raddr (rd_ptr[AW-1:0]),
    .rdata (eng_rd_data)
  );

  txf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .push        (wr_accept),
    .rd_step     (rd_step),
    .release_set (release_set),
    .rewind      (rewind),
    .head_cnt    (head_cnt),
    .wr_p        (wr_ptr),
    .base_p      (base_ptr),
    .rd_p        (rd_ptr),
    .full        (full),
    .empty       (empty)
  );

  txf_sets #(.CW(CW)) u_sets (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .commit_req (commit_req),
    .commit_cnt (commit_cnt),
    .pop        (release_set),
    .nsets      (nsets),
    .head_cnt   (head_cnt)
  );

  assign eng_avail = have_set;
  assign eng_count = head_cnt;
  assign flags     = pack_flags(nsets, empty, full, ovf_q);
endmodule

// File: rtl/txf_dual_pkt_chk.sv
module txf_dual_pkt_chk #(
  parameter int PW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          cpu_wr_en,
  input logic          cnt_hi_we,
  input logic          ovf_clr,
  input logic          eng_rd_en,
  input logic          eng_done_ok,
  input logic          eng_done_fail,
  input logic [PW-1:0] eng_count,
  input logic [7:0]    flags,
  input logic [PW-1:0] rd_p,
  input logic [PW-1:0] base_p
);
  assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (flags == 8'h08));

  assert_overrun_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_en && flags[2] && !clr) |=> flags[0]);

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !ovf_clr && !clr) |=> flags[0]);

  assert_flag_layout_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[7:6] != 2'b11) && (flags[5:4] == 2'b00) && !flags[1] && !(flags[3] && flags[2]));

  assert_commit_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_hi_we && flags[7:6] == 2'd2 && !eng_done_ok && !clr)
      |=> (flags[7:6] == 2'd2) && $stable(eng_count));

  assert_rewind_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done_fail && !eng_done_ok && flags[7:6] != 2'd0 && !cnt_hi_we && !clr)
      |=> (rd_p == base_p) && $stable(flags[7:6]) && $stable(eng_count));

  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done_ok && flags[7:6] != 2'd0 && !cnt_hi_we && !clr)
      |=> (flags[7:6] == $past(flags[7:6]) - 2'd1));

  assert_idle_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_rd_en && flags[7:6] == 2'd0 && !clr) |=> $stable(rd_p));
endmodule

bind txf_dual_pkt txf_dual_pkt_chk #(.PW(PW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .clr           (clr),
  .cpu_wr_en     (cpu_wr_en),
  .cnt_hi_we     (cnt_hi_we),
  .ovf_clr       (ovf_clr),
  .eng_rd_en     (eng_rd_en),
  .eng_done_ok   (eng_done_ok),
  .eng_done_fail (eng_done_fail),
  .eng_count     (eng_count),
  .flags         (flags),
  .rd_p          (rd_ptr),
  .base_p        (base_ptr)
);

// File: tb/sim_txf_dual_pkt.sv
module sim_txf_dual_pkt;
  localparam int DEPTH = 8;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, cpu_wr_en = 1'b0, cnt_lo_we = 1'b0, cnt_hi_we = 1'b0, ovf_clr = 1'b0;
  logic eng_rd_en = 1'b0, eng_done_ok = 1'b0, eng_done_fail = 1'b0;
  logic [7:0] cpu_wr_data = '0, cnt_data = '0;
  logic [7:0] eng_rd_data, flags;
  logic eng_avail;
  logic [CW-1:0] eng_count;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  txf_dual_pkt #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
    .cnt_lo_we(cnt_lo_we), .cnt_hi_we(cnt_hi_we), .cnt_data(cnt_data), .ovf_clr(ovf_clr),
    .eng_rd_en(eng_rd_en), .eng_done_ok(eng_done_ok), .eng_done_fail(eng_done_fail),
    .eng_rd_data(eng_rd_data), .eng_avail(eng_avail), .eng_count(eng_count), .flags(flags)
  );

  function automatic logic [7:0] pat(input int pkt, input int k);
    return 8'((pkt * 37 + k * 11 + 3) & 8'hFF);
  endfunction

  function automatic logic [7:0] exp_flags(input int sets, input bit empty, input bit full, input bit ovf);
    return 8'((sets << 6) | (int'(empty) << 3) | (int'(full) << 2) | int'(ovf));
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] b);
    cpu_wr_en = 1'b1; cpu_wr_data = b; step(); cpu_wr_en = 1'b0;
  endtask

  task automatic commit(input logic [15:0] n);
    cnt_data = n[7:0]; cnt_lo_we = 1'b1; step(); cnt_lo_we = 1'b0;
    cnt_data = n[15:8]; cnt_hi_we = 1'b1; step(); cnt_hi_we = 1'b0;
  endtask

  task automatic take(input logic [7:0] exp, input string req);
    check(req, 16'(eng_rd_data), 16'(exp));
    eng_rd_en = 1'b1; step(); eng_rd_en = 1'b0;
  endtask

  task automatic outcome(input bit ok);
    eng_done_ok = ok; eng_done_fail = !ok; step();
    eng_done_ok = 1'b0; eng_done_fail = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int pkt = 0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 / R11 reset state
    check("R1 flags", 16'(flags), 16'h0008);
    check("R1 avail", 16'(eng_avail), 16'h0);
    check("R1 count", 16'(eng_count), 16'h0);

    // R2 R3 R5 R6 sweep over both set lengths, wrapping repeatedly
    for (int la = 1; la <= 4; la++) begin
      for (int lb = 1; lb <= 4; lb++) begin
        int pa, pb;
        pa = pkt; pb = pkt + 1; pkt += 2;
        for (int k = 0; k < la; k++) wr(pat(pa, k));
        commit(16'(la));
        for (int k = 0; k < lb; k++) wr(pat(pb, k));
        commit(16'(lb));
        check("R3 index two", 16'(flags[7:6]), 16'd2);
        check("R3 head count", 16'(eng_count), 16'(la));
        take(pat(pa, 0), "R2 first byte");
        outcome(1'b0);
        check("R6 count kept", 16'(eng_count), 16'(la));
        check("R6 index kept", 16'(flags[7:6]), 16'd2);
        for (int k = 0; k < la; k++) take(pat(pa, k), "R6 R2 replay");
        outcome(1'b1);
        check("R5 next count", 16'(eng_count), 16'(lb));
        check("R5 index one", 16'(flags[7:6]), 16'd1);
        for (int k = 0; k < lb; k++) take(pat(pb, k), "R2 second set");
        outcome(1'b1);
        check("R5 R11 drained flags", 16'(flags), 16'(exp_flags(0, 1, 0, 0)));
      end
    end

    // R7 R8 R9: full counts read-but-unreleased bytes, overrun discards
    for (int k = 0; k < 5; k++) wr(pat(100, k));
    commit(16'd5);
    for (int k = 0; k < 5; k++) take(pat(100, k), "R2 first pass");
    for (int k = 0; k < 2; k++) wr(pat(101, k));
    check("R7 not full at seven", 16'(flags[2]), 16'd0);
    wr(pat(101, 2));
    check("R7 full", 16'(flags), 16'(exp_flags(1, 0, 1, 0)));
    wr(8'hEE);
    check("R8 overrun set", 16'(flags), 16'(exp_flags(1, 0, 1, 1)));
    commit(16'd3);
    outcome(1'b0);
    for (int k = 0; k < 5; k++) take(pat(100, k), "R6 replay after full");
    outcome(1'b1);
    check("R9 sticky", 16'(flags[0]), 16'd1);
    for (int k = 0; k < 3; k++) take(pat(101, k), "R8 stored bytes");
    outcome(1'b1);
    check("R8 extra byte discarded", 16'(flags), 16'(exp_flags(0, 1, 0, 1)));
    ovf_clr = 1'b1; step(); ovf_clr = 1'b0;
    check("R9 cleared", 16'(flags), 16'h0008);

    // R3 clamp of an oversize count
    for (int k = 0; k < 8; k++) wr(pat(102, k));
    commit(16'h0123);
    check("R3 clamp", 16'(eng_count), 16'(DEPTH));
    for (int k = 0; k < 8; k++) take(pat(102, k), "R2 full set");
    outcome(1'b1);
    check("R3 clamp drained", 16'(flags), 16'h0008);

    // R4 third commit ignored
    wr(pat(103, 0)); commit(16'd1);
    wr(pat(104, 0)); wr(pat(104, 1)); commit(16'd2);
    wr(pat(105, 0)); commit(16'd3);
    check("R4 index stays", 16'(flags[7:6]), 16'd2);
    check("R4 count stays", 16'(eng_count), 16'd1);
    take(pat(103, 0), "R4 set one");
    outcome(1'b1);
    check("R4 next is second", 16'(eng_count), 16'd2);
    for (int k = 0; k < 2; k++) take(pat(104, k), "R4 set two");
    outcome(1'b1);
    check("R4 no third set", 16'(flags), 16'(exp_flags(0, 0, 0, 0)));
    commit(16'd1);
    take(pat(105, 0), "R4 leftover byte");
    outcome(1'b1);
    check("R4 drained", 16'(flags), 16'h0008);

    // R12 idle engine reads
    eng_rd_en = 1'b1; step(); step(); eng_rd_en = 1'b0;
    wr(pat(106, 0)); commit(16'd1);
    take(pat(106, 0), "R12 position unmoved");
    outcome(1'b1);

    // R10 clear
    for (int k = 0; k < 3; k++) wr(pat(107, k));
    commit(16'd3);
    wr(8'h11); wr(8'h22);
    clr = 1'b1; step(); clr = 1'b0;
    check("R10 flags", 16'(flags), 16'h0008);
    check("R10 avail", 16'(eng_avail), 16'd0);
    wr(pat(108, 0)); commit(16'd1);
    check("R10 count after", 16'(eng_count), 16'd1);
    take(pat(108, 0), "R10 fresh data");
    outcome(1'b1);
    check("R10 R11 final", 16'(flags), 16'h0008);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule